// File: doc/BRIEF.md
# BT.656 Byte Stream Decoder with 4:4:4 Expansion

This block receives an 8-bit ITU-R BT.656 byte stream on the byte clock. The stream carries no separate sync pins, so the block finds line and field timing in the timing reference codes embedded in the data. From each accepted code it keeps a field flag, a vertical blanking flag and a horizontal blanking flag. It also produces its own one-clock horizontal and vertical sync pulses, which downstream lock logic can use.

Inside the active part of a visible line, the multiplexed 4:2:2 samples arrive in the order Cb, Y, Cr, Y. The block turns each group of four bytes into two full 24-bit YCbCr pixels, with Cb standing for U and Cr for V. Both pixels of a group carry the same chroma pair. On average there is one pixel for every two input bytes. The two pixels of a group come out on consecutive clocks, followed by two idle clocks.

A timing reference is the byte sequence FF 00 00 XY. In the XY byte, bit 7 is always 1, bit 6 is F, bit 5 is V and bit 4 is H. H=0 marks the start of active video and H=1 marks the end of active video. Bits 3..0 protect the F, V and H bits.

Top module: `bt656_444_decoder`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, the outputs are `field_o`=0, `vblank_o`=1, `hblank_o`=1, `hsync_o`=0, `vsync_o`=0 and `pix_valid_o`=0. A line that was being captured when reset arrived yields no further pixels.
- R2: A timing reference is an XY byte that directly follows the bytes FF, 00, 00. When such a reference is accepted, `field_o`, `vblank_o` and `hblank_o` take XY bits 6, 5 and 4 on the clock after the XY byte, and they hold those values until the next accepted reference.
- R3: `hsync_o` is high for exactly one clock, on the clock after each accepted reference with H=1, and it is low at all other times.
- R4: `vsync_o` is high for exactly one clock, on the clock after an accepted reference with V=1, but only when the V flag held before that reference was 0. No pulse follows the references that come next on the same blanking interval, and none follows reset.
- R5: An XY byte is accepted only if bit 7 is 1 and bits 3..0 equal {V^H, F^H, F^V, F^V^H}. An XY byte that fails either check changes no flag and produces no sync pulse.
- R6: After an accepted reference with H=0 and V=0, the bytes are taken as Cb, Y0, Cr, Y1 repeating. Pixel {Y0,Cb,Cr} appears on `pix_o` with `pix_valid_o`=1 on the clock after the Cr byte. Pixel {Y1,Cb,Cr} follows on the next clock. `pix_o` bits 23:16 hold Y, bits 15:8 hold Cb and bits 7:0 hold Cr.
- R7: After an accepted reference with H=0 and V=1, no pixel is produced until a later reference with H=0 and V=0.
- R8: A data byte of FF ends capture for the rest of the line. The FF 00 00 preamble of the end-of-active code therefore yields no pixel.
- R9: A candidate XY byte is ignored unless the three bytes before it are exactly FF, 00, 00 in that order. For example, FF 00 01 followed by a valid-looking XY changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_i | input | 8 | Stream byte, one per clock |
| field_o | output | 1 | Field flag from the last accepted reference |
| vblank_o | output | 1 | Vertical blanking flag |
| hblank_o | output | 1 | Horizontal blanking flag |
| hsync_o | output | 1 | One-clock pulse after each end-of-active reference |
| vsync_o | output | 1 | One-clock pulse when vertical blanking begins |
| pix_valid_o | output | 1 | Qualifies `pix_o` |
| pix_o | output | 24 | Pixel {Y, Cb, Cr} |

## Verification
A wrong byte-history register or a wrong parity check shows up on the clock after the next XY byte. It appears as a flag that changes when it should hold, or holds when it should change, or as a missing or extra sync pulse. A slip in the Cb/Y/Cr/Y slot counter shows up within four bytes of a start-of-active code: a pixel with swapped fields, a pair whose chroma differs, or a valid strobe in the wrong cycle. A capture gate that ignores FF or the V flag shows up as a pixel during the end-of-active preamble or on a blanking line.

// File: rtl/b656_pkg.sv
package b656_pkg;

    // Bit positions inside the 8-bit XY word; downstream decode depends on them.
    localparam int XY_W     = 8;
    localparam int XY_ONE   = 7;
    localparam int XY_F     = 6;
    localparam int XY_V     = 5;
    localparam int XY_H     = 4;
    localparam int PRE_LEN  = 3;   // bytes of preamble before XY
    localparam int GROUP_SZ = 4;   // bytes per Cb Y Cr Y group

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } ref_bits_t;

    typedef enum logic [1:0] {
        SLOT_CB = 2'd0,
        SLOT_Y0 = 2'd1,
        SLOT_CR = 2'd2,
        SLOT_Y1 = 2'd3
    } slot_e;

    function automatic ref_bits_t xy_fields(input logic [XY_W-1:0] xy);
        ref_bits_t r;
        r.f = xy[XY_F];
        r.v = xy[XY_V];
        r.h = xy[XY_H];
        return r;
    endfunction

    function automatic logic xy_protect_ok(input logic [XY_W-1:0] xy);
        ref_bits_t r;
        logic [3:0] want;
        r    = xy_fields(xy);
        want = {r.v ^ r.h, r.f ^ r.h, r.f ^ r.v, r.f ^ r.v ^ r.h};
        return xy[XY_ONE] && (xy[3:0] == want);
    endfunction

    function automatic slot_e slot_next(input slot_e s);
        return slot_e'(s + 2'd1);
    endfunction

endpackage

// File: rtl/b656_ref_detect.sv
module b656_ref_detect
    import b656_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    output logic              hit,
    output ref_bits_t         code
);
    localparam logic [DATA_W-1:0] ALL_ONE  = '1;
    localparam logic [DATA_W-1:0] ALL_ZERO = '0;

    logic [DATA_W-1:0] hist [PRE_LEN];
    logic [XY_W-1:0]   xy;
    logic              pre_ok;

    always_ff @(posedge clk) begin
        if (rst) hist[0] <= '0;
        else     hist[0] <= din;
    end

    for (genvar i = 1; i < PRE_LEN; i++) begin : g_hist
        always_ff @(posedge clk) begin
            if (rst) hist[i] <= '0;
            else     hist[i] <= hist[i-1];
        end
    end

    always_comb begin
        // oldest byte must be all ones, the rest all zeros
        pre_ok = (hist[PRE_LEN-1] == ALL_ONE);
        for (int k = 0; k < PRE_LEN-1; k++) begin
            pre_ok = pre_ok && (hist[k] == ALL_ZERO);
        end
        xy   = din[DATA_W-1 -: XY_W];
        hit  = pre_ok && xy_protect_ok(xy);
        code = xy_fields(xy);
    end

endmodule

// File: rtl/b656_timing.sv
module b656_timing
    import b656_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hit,
    input  ref_bits_t code,
    output ref_bits_t flags,
    output logic      hsync,
    output logic      vsync
);
    ref_bits_t flags_q;
    logic      hsync_q;
    logic      vsync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '{f: 1'b0, v: 1'b1, h: 1'b1};
            hsync_q <= 1'b0;
            vsync_q <= 1'b0;
        end else begin
            hsync_q <= hit && code.h;
            vsync_q <= hit && code.v && !flags_q.v;
            if (hit) flags_q <= code;
        end
    end

    assign flags = flags_q;
    assign hsync = hsync_q;
    assign vsync = vsync_q;

endmodule

// File: rtl/b656_unpack.sv
module b656_unpack
    import b656_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int PIX_W = 3 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              hit,
    input  ref_bits_t         code,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix
);
    localparam logic [DATA_W-1:0] ALL_ONE = '1;

    logic              run_q;
    slot_e             slot_q;
    logic [DATA_W-1:0] cb_q, y0_q, cr_q;
    logic              vld_q;
    logic [PIX_W-1:0]  pix_q;
    logic              take;

    assign take = run_q && (din != ALL_ONE);

    // capture gate: opened by a visible start code, closed by FF or any other code
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            slot_q <= SLOT_CB;
        end else if (hit) begin
            run_q  <= !code.h && !code.v;
            slot_q <= SLOT_CB;
        end else if (din == ALL_ONE) begin
            run_q  <= 1'b0;
        end else if (take) begin
            slot_q <= slot_next(slot_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cb_q  <= '0;
            y0_q  <= '0;
            cr_q  <= '0;
            vld_q <= 1'b0;
            pix_q <= '0;
        end else begin
            vld_q <= 1'b0;
            if (take) begin
                unique case (slot_q)
                    SLOT_CB: cb_q <= din;
                    SLOT_Y0: y0_q <= din;
                    SLOT_CR: begin
                        cr_q  <= din;
                        pix_q <= {y0_q, cb_q, din};
                        vld_q <= 1'b1;
                    end
                    SLOT_Y1: begin
                        pix_q <= {din, cb_q, cr_q};
                        vld_q <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign pix_valid = vld_q;
    assign pix       = pix_q;

endmodule

// File: rtl/bt656_444_decoder.sv
module bt656_444_decoder
    import b656_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int PIX_W = 3 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] byte_i,
    output logic              field_o,
    output logic              vblank_o,
    output logic              hblank_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              pix_valid_o,
    output logic [PIX_W-1:0]  pix_o
);
    logic      ref_hit;
    ref_bits_t ref_code;
    ref_bits_t flags;

    b656_ref_detect #(.DATA_W(DATA_W)) u_detect (
        .clk  (clk),
        .rst  (rst),
        .din  (byte_i),
        .hit  (ref_hit),
        .code (ref_code)
    );

    b656_timing u_timing (
        .clk   (clk),
        .rst   (rst),
        .hit   (ref_hit),
        .code  (ref_code),
        .flags (flags),
        .hsync (hsync_o),
        .vsync (vsync_o)
    );

    b656_unpack #(.DATA_W(DATA_W)) u_unpack (
        .clk       (clk),
        .rst       (rst),
        .din       (byte_i),
        .hit       (ref_hit),
        .code      (ref_code),
        .pix_valid (pix_valid_o),
        .pix       (pix_o)
    );

    assign field_o  = flags.f;
    assign vblank_o = flags.v;
    assign hblank_o = flags.h;

endmodule

// File: rtl/b656_checker.sv
module b656_checker #(
    parameter int DATA_W = 8,
    localparam int PIX_W = 3 * DATA_W
) (
    input logic             clk,
    input logic             rst,
    input logic             vblank_o,
    input logic             hblank_o,
    input logic             hsync_o,
    input logic             vsync_o,
    input logic             pix_valid_o,
    input logic [PIX_W-1:0] pix_o
);
    a_r3_hsync_one_clock: assert property (@(posedge clk) disable iff (rst)
        hsync_o |=> !hsync_o);

    a_r3_hsync_with_hblank: assert property (@(posedge clk) disable iff (rst)
        hsync_o |-> hblank_o);

    a_r4_vsync_at_vblank_rise: assert property (@(posedge clk) disable iff (rst)
        vsync_o |-> (vblank_o && !$past(vblank_o)));

    a_r4_vsync_one_clock: assert property (@(posedge clk) disable iff (rst)
        vsync_o |=> !vsync_o);

    a_r7_valid_in_active: assert property (@(posedge clk) disable iff (rst)
        pix_valid_o |-> (!vblank_o && !hblank_o));

    a_r6_pair_shares_chroma: assert property (@(posedge clk) disable iff (rst)
        $rose(pix_valid_o) |=> (pix_valid_o && $stable(pix_o[2*DATA_W-1:0])));

endmodule

bind bt656_444_decoder b656_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .vblank_o    (vblank_o),
    .hblank_o    (hblank_o),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .pix_valid_o (pix_valid_o),
    .pix_o       (pix_o)
);

// File: tb/bt656_444_decoder_tb.sv
module bt656_444_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV         = 61;
    localparam int WDOG       = 20000;

    // row: {byte, field, vblank, hblank, hsync, vsync, valid, pixel}
    localparam logic [37:0] VEC [0:NV-1] = '{
        {8'hFF, 6'b011000, 24'h0},      // 0  R2 preamble, nothing changes
        {8'h00, 6'b011000, 24'h0},
        {8'h00, 6'b011000, 24'h0},
        {8'h80, 6'b000000, 24'h0},      // 3  R2 start code F0 V0; R4 no pulse after reset
        {8'h10, 6'b000000, 24'h0},      // Cb
        {8'h20, 6'b000000, 24'h0},      // Y0
        {8'h30, 6'b000001, 24'h201030}, // 6  R6 first pixel
        {8'h40, 6'b000001, 24'h401030}, // 7  R6 second pixel
        {8'h50, 6'b000000, 24'h0},
        {8'h60, 6'b000000, 24'h0},
        {8'h70, 6'b000001, 24'h605070},
        {8'h80, 6'b000001, 24'h805070},
        {8'hFF, 6'b000000, 24'h0},      // 12 R8 FF stops capture
        {8'h00, 6'b000000, 24'h0},
        {8'h00, 6'b000000, 24'h0},      // 14 R8 no preamble pixel
        {8'h9D, 6'b001100, 24'h0},      // 15 R3 end code -> hsync
        {8'h11, 6'b001000, 24'h0},      // 16 R3 pulse one clock
        {8'hFF, 6'b001000, 24'h0},
        {8'h00, 6'b001000, 24'h0},
        {8'h00, 6'b001000, 24'h0},
        {8'hAB, 6'b010010, 24'h0},      // 20 R4 V rises -> vsync
        {8'h12, 6'b010000, 24'h0},      // 21 R7 blank line, no pixels
        {8'h22, 6'b010000, 24'h0},
        {8'h32, 6'b010000, 24'h0},
        {8'h42, 6'b010000, 24'h0},
        {8'hFF, 6'b010000, 24'h0},
        {8'h00, 6'b010000, 24'h0},
        {8'h00, 6'b010000, 24'h0},
        {8'hB6, 6'b011100, 24'h0},      // 28 R4 V stays 1 -> no vsync
        {8'hFF, 6'b011000, 24'h0},
        {8'h00, 6'b011000, 24'h0},
        {8'h00, 6'b011000, 24'h0},
        {8'h81, 6'b011000, 24'h0},      // 32 R5 bad protection ignored
        {8'hFF, 6'b011000, 24'h0},
        {8'h00, 6'b011000, 24'h0},
        {8'h00, 6'b011000, 24'h0},
        {8'hDA, 6'b101100, 24'h0},      // 36 R2 F1 V0 H1
        {8'hFF, 6'b101000, 24'h0},
        {8'h00, 6'b101000, 24'h0},
        {8'h01, 6'b101000, 24'h0},
        {8'hC7, 6'b101000, 24'h0},      // 40 R9 broken preamble ignored
        {8'hFF, 6'b101000, 24'h0},
        {8'h00, 6'b101000, 24'h0},
        {8'h00, 6'b101000, 24'h0},
        {8'hC7, 6'b100000, 24'h0},      // 44 R2 start code F1 V0
        {8'h0A, 6'b100000, 24'h0},
        {8'h0B, 6'b100000, 24'h0},
        {8'h0C, 6'b100001, 24'h0B0A0C}, // 47 R6
        {8'h0D, 6'b100001, 24'h0D0A0C}, // 48 R6
        {8'hFF, 6'b100000, 24'h0},      // 49 R8
        {8'h00, 6'b100000, 24'h0},
        {8'h00, 6'b100000, 24'h0},      // 51 R8 no garbage pixel
        {8'hDA, 6'b101100, 24'h0},      // 52 R3
        {8'hFF, 6'b101000, 24'h0},
        {8'h00, 6'b101000, 24'h0},
        {8'h00, 6'b101000, 24'h0},
        {8'h1D, 6'b101000, 24'h0},      // 56 R5 bit 7 clear ignored
        {8'hFF, 6'b101000, 24'h0},
        {8'h00, 6'b101000, 24'h0},
        {8'h00, 6'b101000, 24'h0},
        {8'hF1, 6'b111110, 24'h0}       // 60 R4 V rises again
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  byte_i = 8'h00;
    logic        field_o, vblank_o, hblank_o, hsync_o, vsync_o, pix_valid_o;
    logic [23:0] pix_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    bt656_444_decoder u_dut (
        .clk         (clk),
        .rst         (rst),
        .byte_i      (byte_i),
        .field_o     (field_o),
        .vblank_o    (vblank_o),
        .hblank_o    (hblank_o),
        .hsync_o     (hsync_o),
        .vsync_o     (vsync_o),
        .pix_valid_o (pix_valid_o),
        .pix_o       (pix_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: got cycle %0d expected end before %0d", cyc, WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // compare all outputs against a 6-bit flag word and a pixel
    task automatic check(input string tag, input logic [5:0] ef, input logic [23:0] ep);
        logic [5:0] af;
        logic       bad;
        af  = {field_o, vblank_o, hblank_o, hsync_o, vsync_o, pix_valid_o};
        bad = (af !== ef) || (ef[0] && (pix_o !== ep));
        n_chk = n_chk + 1;
        if (bad) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: got flags %b pix %h expected flags %b pix %h",
                     tag, af, pix_o, ef, ep);
        end
    endtask

    task automatic push(input logic [7:0] b);
        byte_i = b;
        @(negedge clk);
    endtask

    initial begin
        // R1: state during reset
        repeat (3) @(negedge clk);
        check("R1 during reset", 6'b011000, 24'h0);
        rst = 1'b0;

        // table walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            push(VEC[i][37:30]);
            check($sformatf("R2-row%0d R3/R4/R6 fields", i), VEC[i][29:24], VEC[i][23:0]);
        end

        // R1: reset in the middle of an active line
        push(8'hFF); push(8'h00); push(8'h00);
        push(8'h80);
        check("R2 start code before reset", 6'b000000, 24'h0);
        push(8'h55); push(8'h66);
        rst = 1'b1;
        push(8'h77);
        check("R1 mid-line reset", 6'b011000, 24'h0);
        rst = 1'b0;
        push(8'h77);
        check("R1 first clock after reset", 6'b011000, 24'h0);
        push(8'h88);
        check("R1 no pixel after reset", 6'b011000, 24'h0);

        // R6: a fresh line after reset decodes cleanly
        push(8'hFF); push(8'h00); push(8'h00); push(8'h80);
        push(8'hA1); push(8'hA2);
        push(8'hA3);
        check("R6 pixel 0 after recovery", 6'b000001, 24'hA2A1A3);
        push(8'hA4);
        check("R6 pixel 1 after recovery", 6'b000001, 24'hA4A1A3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule